// File: doc/BRIEF.md
# Single-Address Serializer Buffer Sequencer

This block sits between one bus port address and a bank of audio serializer data buffers. A DMA engine or CPU writes every transmit word to one shared address and reads every receive word from another. The block steers each access to the next active serializer of the matching direction, walking the active set in ascending index order and skipping indices that are inactive or that face the other way.

Each data-ready event opens a new time slot for its direction. A transmit event loads the words written during the closing slot onto the serializer outputs. A receive event captures fresh serializer input words, and later reads return them in order. When an event closes a slot in which not every active serializer of that direction was serviced, a sticky underrun or overrun flag is raised. Accesses with nowhere to go set a sticky sequencing-error flag. A per-direction select input takes the port path out of use without side effects.

Top module: `ser_buf_seq`

## Requirements
- R1: After reset all three status flags are 0, every lane of `ser_tx_data` is 0 and `port_rdata` is 0.
- R2: Within a transmit slot, accepted writes fill the active transmit serializers in ascending index order, skipping gaps. For example, with transmit set {0,4,5,7} four writes fill 0, 4, 5 and 7. The written words appear on `ser_tx_data` (lane i at bits i*DW+DW-1 to i*DW) on the clock edge that handles the next transmit event.
- R3: A receive event captures `ser_rx_data` for the active receive serializers. Accepted reads in that slot return the captured words combinationally on `port_rdata`, in ascending index order of the active receive set.
- R4: A transmit event that closes an open slot with at least one active transmit serializer left unwritten sets `tx_underrun` on that edge. The first event after reset opens a slot and never flags.
- R5: A receive event that closes an open slot with at least one active receive serializer left unread sets `rx_overrun` on that edge.
- R6: A write or read that has no target gets no effect and sets `seq_err`, and such a read returns 0. An access has no target when it goes beyond the active count, comes before the first event of its direction, or arrives in the same cycle as that direction's event.
- R7: While `cfg_tx_bussel` (or `cfg_rx_bussel`) is 1, port writes (or reads) in that direction are ignored: no buffer or pointer change, no `seq_err`, and `port_rdata` stays 0.
- R8: At a transmit event, every lane not written in the closing slot, including inactive and receive lanes, is driven to 0.
- R9: `status_clr` is write-one-to-clear, with bit 0 for `tx_underrun`, bit 1 for `rx_overrun` and bit 2 for `seq_err`. A new set in the same cycle wins over a clear.
- R10: A serializer counts as transmit when `cfg_active[i]` and `cfg_is_tx[i]` are 1, and as receive when `cfg_active[i]` is 1 and `cfg_is_tx[i]` is 0. Each direction's set is sampled at its own event and held for the slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | NS | Serializer active mask |
| cfg_is_tx | input | NS | Per-serializer direction, 1 = transmit |
| cfg_tx_bussel | input | 1 | 1 removes the transmit port path |
| cfg_rx_bussel | input | 1 | 1 removes the receive port path |
| tx_slot_evt | input | 1 | Transmit data-ready event, one-cycle pulse |
| rx_slot_evt | input | 1 | Receive data-ready event, one-cycle pulse |
| port_wr | input | 1 | Write strobe at the shared transmit address |
| port_wdata | input | DW | Write data |
| port_rd | input | 1 | Read strobe at the shared receive address |
| port_rdata | output | DW | Read data, valid in the strobe cycle |
| ser_tx_data | output | NS*DW | Words handed to the transmit serializers |
| ser_rx_data | input | NS*DW | Words offered by the receive serializers |
| status_clr | input | 3 | Write-one-to-clear for the status flags |
| tx_underrun | output | 1 | Sticky transmit underrun |
| rx_overrun | output | 1 | Sticky receive overrun |
| seq_err | output | 1 | Sticky sequencing error |

## Verification
The bench builds the block with NS=8 and DW=16. Eight lanes are few enough that random masks often include the highest index, leave long gaps and come out empty, and 16-bit words keep lane mix-ups visible. Random traffic changes the masks, directions and select bits between slots, so that early events, surplus accesses and accesses coinciding with an event all occur. Every cycle is compared against a lane-by-lane model.

// File: rtl/ser_seq_pkg.sv
package ser_seq_pkg;
  localparam int ST_TXU = 0;
  localparam int ST_RXO = 1;
  localparam int ST_SEQ = 2;
  localparam int ST_W   = 3;
  typedef logic [ST_W-1:0] status_t;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ser_next_idx.sv
module ser_next_idx #(
  parameter int NS = 16,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0] mask,
  input  logic [IW-1:0] cur,
  input  logic          from_start,
  output logic [IW-1:0] nxt,
  output logic          found
);
  always_comb begin
    nxt   = '0;
    found = 1'b0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (mask[i] && (from_start || (i > int'(cur)))) begin
        nxt   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_tx_path.sv
module ser_tx_path #(
  parameter int NS = 16,
  parameter int DW = 32,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_evt,
  input  logic [NS-1:0]  mask_cfg,
  input  logic           path_en,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  output logic [NS*DW-1:0] ser_out,
  output logic           underrun_hit,
  output logic           extra_hit
);
  logic [NS-1:0] mask_q, mask_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          done_q, done_d;
  logic          open_q, open_d;
  logic [NS-1:0] wrote_q, wrote_d;
  logic [IW-1:0] first_idx, next_idx;
  logic          first_found, next_found;
  logic          accept;

  ser_next_idx #(.NS(NS)) u_first (
    .mask(mask_cfg), .cur('0), .from_start(1'b1),
    .nxt(first_idx), .found(first_found));

  ser_next_idx #(.NS(NS)) u_next (
    .mask(mask_q), .cur(ptr_q), .from_start(1'b0),
    .nxt(next_idx), .found(next_found));

  assign accept       = path_en && wr && !slot_evt && open_q && !done_q;
  assign extra_hit    = path_en && wr && !accept;
  assign underrun_hit = slot_evt && open_q && !done_q;

  always_comb begin
    mask_d  = mask_q;
    ptr_d   = ptr_q;
    done_d  = done_q;
    open_d  = open_q;
    wrote_d = wrote_q;
    if (slot_evt) begin
      mask_d  = mask_cfg;
      ptr_d   = first_idx;
      done_d  = !first_found;
      open_d  = 1'b1;
      wrote_d = '0;
    end else if (accept) begin
      wrote_d[ptr_q] = 1'b1;
      if (next_found) ptr_d  = next_idx;
      else            done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b1;
      open_q  <= 1'b0;
      wrote_q <= '0;
    end else begin
      mask_q  <= mask_d;
      ptr_q   <= ptr_d;
      done_q  <= done_d;
      open_q  <= open_d;
      wrote_q <= wrote_d;
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_lane
    logic [DW-1:0] buf_q;
    logic [DW-1:0] out_q;
    logic          buf_en;
    logic [DW-1:0] out_d;

    assign buf_en = accept && (ptr_q == IW'(i));
    assign out_d  = wrote_q[i] ? buf_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      buf_q <= '0;
      else if (buf_en) buf_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_q <= '0;
      else if (slot_evt) out_q <= out_d;
    end

    assign ser_out[i*DW +: DW] = out_q;

    // R8: a lane left unwritten in the closing slot goes quiet
    a_r8_unwritten_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_evt && !wrote_q[i]) |=> (out_q == '0));
  end

  // R2: while the slot has work left, the pointer sits on an active lane
  a_r2_ptr_on_active: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !done_q) |-> mask_q[ptr_q]);

  // R2: each accepted write moves the pointer upward or ends the slot
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((ptr_q > $past(ptr_q)) || done_q));

  // R6: a finished slot stays finished until the next event
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !slot_evt) |=> done_q);
endmodule

// File: rtl/ser_rx_path.sv
module ser_rx_path #(
  parameter int NS = 16,
  parameter int DW = 32,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_evt,
  input  logic [NS-1:0]    mask_cfg,
  input  logic             path_en,
  input  logic             rd,
  input  logic [NS*DW-1:0] ser_in,
  output logic [DW-1:0]    rdata,
  output logic             overrun_hit,
  output logic             extra_hit
);
  logic [NS-1:0] mask_q, mask_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          done_q, done_d;
  logic          open_q, open_d;
  logic [IW-1:0] first_idx, next_idx;
  logic          first_found, next_found;
  logic          accept;
  logic [DW-1:0] hold_q [NS];

  ser_next_idx #(.NS(NS)) u_first (
    .mask(mask_cfg), .cur('0), .from_start(1'b1),
    .nxt(first_idx), .found(first_found));

  ser_next_idx #(.NS(NS)) u_next (
    .mask(mask_q), .cur(ptr_q), .from_start(1'b0),
    .nxt(next_idx), .found(next_found));

  assign accept      = path_en && rd && !slot_evt && open_q && !done_q;
  assign extra_hit   = path_en && rd && !accept;
  assign overrun_hit = slot_evt && open_q && !done_q;
  assign rdata       = accept ? hold_q[ptr_q] : '0;

  always_comb begin
    mask_d = mask_q;
    ptr_d  = ptr_q;
    done_d = done_q;
    open_d = open_q;
    if (slot_evt) begin
      mask_d = mask_cfg;
      ptr_d  = first_idx;
      done_d = !first_found;
      open_d = 1'b1;
    end else if (accept) begin
      if (next_found) ptr_d  = next_idx;
      else            done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      done_q <= 1'b1;
      open_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
      done_q <= done_d;
      open_q <= open_d;
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_lane
    logic [DW-1:0] hold_d;
    assign hold_d = mask_cfg[i] ? ser_in[i*DW +: DW] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hold_q[i] <= '0;
      else if (slot_evt) hold_q[i] <= hold_d;
    end
  end

  // R3: reads are served only from lanes in the sampled receive set
  a_r3_ptr_on_active: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !done_q) |-> mask_q[ptr_q]);

  // R3: each accepted read moves the pointer upward or ends the slot
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((ptr_q > $past(ptr_q)) || done_q));

  // R7: with the path removed the pointer does not move
  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_en && !slot_evt) |=> $stable(ptr_q));
endmodule

// File: rtl/ser_buf_seq.sv
module ser_buf_seq
  import ser_seq_pkg::*;
#(
  parameter int NS = 16,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    cfg_active,
  input  logic [NS-1:0]    cfg_is_tx,
  input  logic             cfg_tx_bussel,
  input  logic             cfg_rx_bussel,
  input  logic             tx_slot_evt,
  input  logic             rx_slot_evt,
  input  logic             port_wr,
  input  logic [DW-1:0]    port_wdata,
  input  logic             port_rd,
  output logic [DW-1:0]    port_rdata,
  output logic [NS*DW-1:0] ser_tx_data,
  input  logic [NS*DW-1:0] ser_rx_data,
  input  logic [ST_W-1:0]  status_clr,
  output logic             tx_underrun,
  output logic             rx_overrun,
  output logic             seq_err
);
  logic    rst_n_s;
  logic    txu_hit, rxo_hit, tx_extra, rx_extra;
  status_t st_q, st_d, st_set;

  ser_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  ser_tx_path #(.NS(NS), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .slot_evt(tx_slot_evt),
    .mask_cfg(cfg_active & cfg_is_tx), .path_en(!cfg_tx_bussel),
    .wr(port_wr), .wdata(port_wdata), .ser_out(ser_tx_data),
    .underrun_hit(txu_hit), .extra_hit(tx_extra));

  ser_rx_path #(.NS(NS), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .slot_evt(rx_slot_evt),
    .mask_cfg(cfg_active & ~cfg_is_tx), .path_en(!cfg_rx_bussel),
    .rd(port_rd), .ser_in(ser_rx_data), .rdata(port_rdata),
    .overrun_hit(rxo_hit), .extra_hit(rx_extra));

  always_comb begin
    st_set         = '0;
    st_set[ST_TXU] = txu_hit;
    st_set[ST_RXO] = rxo_hit;
    st_set[ST_SEQ] = tx_extra || rx_extra;
    st_d           = (st_q & ~status_clr) | st_set;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= '0;
    else          st_q <= st_d;
  end

  assign tx_underrun = st_q[ST_TXU];
  assign rx_overrun  = st_q[ST_RXO];
  assign seq_err     = st_q[ST_SEQ];

  // R4: an unfinished transmit slot always leaves the flag set
  a_r4_underrun_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    txu_hit |=> tx_underrun);

  // R5: an unfinished receive slot always leaves the flag set
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    rxo_hit |=> rx_overrun);

  // R9: flags hold until their clear bit is written
  a_r9_txu_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_underrun && !status_clr[ST_TXU]) |=> tx_underrun);

  a_r9_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seq_err && !status_clr[ST_SEQ]) |=> seq_err);

  // R7: no sequencing error comes from a removed path
  a_r7_no_err_when_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_tx_bussel && cfg_rx_bussel && !seq_err) |=> !seq_err);
endmodule

// File: tb/sim_ser_buf_seq.sv
`timescale 1ns/1ps
module sim_ser_buf_seq;
  localparam int NS = 8;
  localparam int DW = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NS-1:0]    cfg_active, cfg_is_tx;
  logic             cfg_tx_bussel, cfg_rx_bussel;
  logic             tx_slot_evt, rx_slot_evt;
  logic             port_wr, port_rd;
  logic [DW-1:0]    port_wdata;
  logic [DW-1:0]    port_rdata;
  logic [NS*DW-1:0] ser_tx_data, ser_rx_data;
  logic [2:0]       status_clr;
  logic             tx_underrun, rx_overrun, seq_err;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // model state
  logic [DW-1:0] m_buf [NS];
  logic [DW-1:0] m_hold[NS];
  logic [DW-1:0] m_out [NS];
  bit  m_wrote[NS];
  int  tx_list[NS], rx_list[NS];
  int  tx_n, tx_cnt, rx_n, rx_cnt;
  bit  tx_open, rx_open;
  bit  m_txu, m_rxo, m_seq;

  always #2.5 clk = ~clk;

  ser_buf_seq #(.NS(NS), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_is_tx(cfg_is_tx),
    .cfg_tx_bussel(cfg_tx_bussel), .cfg_rx_bussel(cfg_rx_bussel),
    .tx_slot_evt(tx_slot_evt), .rx_slot_evt(rx_slot_evt),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rd(port_rd),
    .port_rdata(port_rdata), .ser_tx_data(ser_tx_data), .ser_rx_data(ser_rx_data),
    .status_clr(status_clr), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
    .seq_err(seq_err));

  function automatic logic [DW-1:0] lane(input logic [NS*DW-1:0] v, input int i);
    return v[i*DW +: DW];
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      m_buf[i] = '0; m_hold[i] = '0; m_out[i] = '0; m_wrote[i] = 0;
    end
    tx_n = 0; tx_cnt = 0; rx_n = 0; rx_cnt = 0;
    tx_open = 0; rx_open = 0;
    m_txu = 0; m_rxo = 0; m_seq = 0;
  endtask

  task automatic idle_inputs();
    tx_slot_evt = 0; rx_slot_evt = 0; port_wr = 0; port_rd = 0; status_clr = '0;
  endtask

  // one clock: inputs are set at a falling edge; R10 masks sampled at events
  task automatic cycle();
    logic [DW-1:0] exp_rd;
    bit tx_acc, rx_acc, s_txu, s_rxo, s_seq;
    string rtag;
    #1;
    tx_acc = port_wr && !cfg_tx_bussel && !tx_slot_evt && tx_open && (tx_cnt < tx_n);
    rx_acc = port_rd && !cfg_rx_bussel && !rx_slot_evt && rx_open && (rx_cnt < rx_n);
    exp_rd = rx_acc ? m_hold[rx_list[rx_cnt]] : '0;
    rtag = cfg_rx_bussel ? "R7 rdata" : (rx_acc ? "R3 rdata" : "R6 rdata");
    if (port_rd) chk(rtag, port_rdata, exp_rd);
    s_txu = tx_slot_evt && tx_open && (tx_cnt < tx_n);
    s_rxo = rx_slot_evt && rx_open && (rx_cnt < rx_n);
    s_seq = (port_wr && !cfg_tx_bussel && !tx_acc) || (port_rd && !cfg_rx_bussel && !rx_acc);
    if (tx_slot_evt) begin
      for (int i = 0; i < NS; i++) begin
        m_out[i] = m_wrote[i] ? m_buf[i] : '0;
        m_wrote[i] = 0;
      end
      tx_n = 0;
      for (int i = 0; i < NS; i++)
        if (cfg_active[i] && cfg_is_tx[i]) begin tx_list[tx_n] = i; tx_n++; end
      tx_cnt = 0; tx_open = 1;
    end else if (tx_acc) begin
      m_buf[tx_list[tx_cnt]] = port_wdata;
      m_wrote[tx_list[tx_cnt]] = 1;
      tx_cnt++;
    end
    if (rx_slot_evt) begin
      rx_n = 0;
      for (int i = 0; i < NS; i++) begin
        m_hold[i] = (cfg_active[i] && !cfg_is_tx[i]) ? lane(ser_rx_data, i) : '0;
        if (cfg_active[i] && !cfg_is_tx[i]) begin rx_list[rx_n] = i; rx_n++; end
      end
      rx_cnt = 0; rx_open = 1;
    end else if (rx_acc) begin
      rx_cnt++;
    end
    m_txu = (m_txu && !status_clr[0]) || s_txu;
    m_rxo = (m_rxo && !status_clr[1]) || s_rxo;
    m_seq = (m_seq && !status_clr[2]) || s_seq;
    @(negedge clk);
    for (int i = 0; i < NS; i++) chk("R2 tx lane", lane(ser_tx_data, i), m_out[i]);
    chk("R4 underrun", DW'(tx_underrun), DW'(m_txu));
    chk("R5 overrun", DW'(rx_overrun), DW'(m_rxo));
    chk("R6 seq_err", DW'(seq_err), DW'(m_seq));
    idle_inputs();
  endtask

  task automatic rand_rx();
    for (int i = 0; i < NS; i++) ser_rx_data[i*DW +: DW] = DW'($urandom);
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    port_wr = 1; port_wdata = d; cycle();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    cfg_active = '0; cfg_is_tx = '0; cfg_tx_bussel = 0; cfg_rx_bussel = 0;
    port_wdata = '0; ser_rx_data = '0;
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < NS; i++) chk("R1 tx lane", lane(ser_tx_data, i), '0);
    chk("R1 rdata", port_rdata, '0);
    chk("R1 flags", DW'({tx_underrun, rx_overrun, seq_err}), '0);

    // R6: write before any transmit event has no target
    write_word(16'hDEAD);
    chk("R6 early write", DW'(seq_err), 1);
    status_clr = 3'b100; cycle();

    // R10: transmit set {0,4,5,7}, receive set {1,2,3,6}
    cfg_active = 8'hFF; cfg_is_tx = 8'b1011_0001;
    rand_rx();
    tx_slot_evt = 1; rx_slot_evt = 1; cycle();
    chk("R4 first event", DW'(tx_underrun), 0);
    for (int k = 0; k < 4; k++) write_word(16'hA000 + DW'(k));
    begin
      int rxl[4];
      logic [DW-1:0] cap[NS];
      rxl = '{1, 2, 3, 6};
      for (int i = 0; i < NS; i++) cap[i] = m_hold[i];
      rand_rx();
      for (int k = 0; k < 4; k++) begin
        port_rd = 1; #1;
        chk("R3 read order", port_rdata, cap[rxl[k]]);
        cycle();
      end
    end
    tx_slot_evt = 1; rx_slot_evt = 1; cycle();
    chk("R2 lane4", lane(ser_tx_data, 4), 16'hA001);
    chk("R2 lane7", lane(ser_tx_data, 7), 16'hA003);
    chk("R10 rx lane on tx side", lane(ser_tx_data, 1), '0);
    chk("R5 full slot", DW'(rx_overrun), 0);

    // R4/R8: partial slot
    write_word(16'hB000); write_word(16'hB001);
    tx_slot_evt = 1; cycle();
    chk("R4 underrun", DW'(tx_underrun), 1);
    chk("R8 lane5", lane(ser_tx_data, 5), '0);
    chk("R8 lane7", lane(ser_tx_data, 7), '0);
    chk("R2 lane4 partial", lane(ser_tx_data, 4), 16'hB001);

    // R5: receive slot closed unread
    rx_slot_evt = 1; cycle();
    port_rd = 1; cycle();
    rx_slot_evt = 1; cycle();
    chk("R5 overrun", DW'(rx_overrun), 1);

    // R9: clear, then clear colliding with a set
    status_clr = 3'b011; cycle();
    chk("R9 cleared", DW'({tx_underrun, rx_overrun}), 0);
    tx_slot_evt = 1; status_clr = 3'b001; cycle();
    chk("R9 set wins", DW'(tx_underrun), 1);
    status_clr = 3'b111; cycle();

    // R6: extra write beyond the count
    for (int k = 0; k < 5; k++) write_word(16'hC000 + DW'(k));
    chk("R6 extra write", DW'(seq_err), 1);
    tx_slot_evt = 1; cycle();
    chk("R6 extra ignored", lane(ser_tx_data, 7), 16'hC003);
    status_clr = 3'b111; cycle();

    // R7: path removed
    cfg_tx_bussel = 1; cfg_rx_bussel = 1;
    write_word(16'hEEEE);
    port_rd = 1; #1; chk("R7 rdata zero", port_rdata, '0); cycle();
    chk("R7 no seq_err", DW'(seq_err), 0);
    tx_slot_evt = 1; cycle();
    chk("R7 write ignored", lane(ser_tx_data, 0), '0);
    cfg_tx_bussel = 0; cfg_rx_bussel = 0;
    status_clr = 3'b111; cycle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 16);
      if ($urandom % 40 == 0) begin
        cfg_active = NS'($urandom); cfg_is_tx = NS'($urandom);
      end
      if ($urandom % 50 == 0) begin
        cfg_tx_bussel = ($urandom % 8 == 0);
        cfg_rx_bussel = ($urandom % 8 == 0);
      end
      tx_slot_evt = (r == 0) || (r == 2);
      rx_slot_evt = (r == 1) || (r == 2);
      port_wr = ($urandom % 3 == 0);
      port_rd = ($urandom % 3 == 0);
      port_wdata = DW'($urandom);
      status_clr = ($urandom % 10 == 0) ? 3'($urandom) : 3'b000;
      rand_rx();
      cycle();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule